// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block produces a single output pulse of a programmed number of clock cycles each time a trigger is accepted. It stands in for an RC-timed monostable: a cycle counter sets the pulse length, loaded from the `pulse_len` input. Two asynchronous trigger pins are synchronized. One fires on a falling edge and the other on a rising edge. Each edge only counts while the other pin sits at its enabling level.

An active-low clear input overrides everything else. It forces the output low in the same cycle and ends any interval in progress. Its release never starts a pulse on its own. A trigger that arrives while the pulse is already high restarts the full interval, unless the lockout mode input is set. With lockout set, triggers are ignored for as long as the pulse is active. The pulse output has a complementary companion.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears. After reset, `pulse_q` is 0 and `pulse_qn` is 1 until a trigger is accepted.
- R2: A 1-to-0 change on `trig_fall_n` is a trigger when `trig_rise` is 0 and `clr_n` is 1. If the input changes in cycle k, `pulse_q` is 1 from cycle k+3. Cycles k+1 and k+2 are the two synchronizer stages, and the accepted edge registers at k+3.
- R3: A 0-to-1 change on `trig_rise` is a trigger when `trig_fall_n` is 1 and `clr_n` is 1. It has the same k+3 latency as R2.
- R4: An edge is ignored when the other trigger pin is at its blocking level. This covers a falling `trig_fall_n` while `trig_rise` is 1, and a rising `trig_rise` while `trig_fall_n` is 0. The opposite-direction edges (rising `trig_fall_n`, falling `trig_rise`) are never triggers.
- R5: After an accepted trigger with no further trigger, `pulse_q` stays 1 for exactly N cycles, where N is the `pulse_len` value at acceptance. A value of 0 acts as 1.
- R6: A trigger accepted while the pulse is high, with `no_retrig` = 0, reloads the full interval. `pulse_q` stays 1 without a gap until N cycles after that trigger registers.
- R7: While `clr_n` is 0, `pulse_q` is 0 in the same cycle, the running interval is discarded, and no trigger edge can start a pulse.
- R8: A 0-to-1 change of `clr_n` with no trigger edge detected in that cycle leaves `pulse_q` at 0.
- R9: `clr_n` is used unsynchronized. A trigger edge reaches the detector two cycles after the pin changes. If `clr_n` is 1 in that cycle, the trigger is accepted, even if `clr_n` was 0 in the cycle before.
- R10: With `no_retrig` = 1, triggers arriving while the pulse is active are ignored, and the pulse ends N cycles after its start. A trigger after the pulse ends is accepted normally.
- R11: `pulse_qn` is always the complement of `pulse_q`.
- R12: Changing `pulse_len` during a pulse does not alter the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_fall_n | input | 1 | Asynchronous trigger, fires on a falling edge, enables rising triggers while high |
| trig_rise | input | 1 | Asynchronous trigger, fires on a rising edge, enables falling triggers while low |
| clr_n | input | 1 | Direct clear, active low, synchronous to `clk` |
| no_retrig | input | 1 | 1 selects lockout: triggers ignored during an active pulse |
| pulse_len | input | CNT_W | Pulse length in clock cycles, captured when a trigger is accepted |
| pulse_q | output | 1 | Pulse output |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
The output reacts to trigger pins three clock edges after the pin changes: two synchronizer stages, then the register that holds the active state. A pulse of N cycles therefore occupies cycles k+3 through k+2+N after the trigger is driven in cycle k. Clear acts on the output in the same cycle it is driven, because its gating is combinational.

The driver drives every input 2 ns after a rising edge. It then queues the expected level of the output for each exact future cycle number. The monitor compares one queued item per cycle at the falling edge, so every comparison lands on the cycle the timing above predicts.

// File: rtl/oneshot_pkg.sv
// Package: shared constants and types for the retriggerable one-shot.
// Assumes: nothing; pure declarations.
package oneshot_pkg;

    // Number of flops in each trigger synchronizer chain (minimum 2).
    localparam int unsigned SYNC_STAGES = 2;

    // Retrigger behaviour while a pulse is active.
    typedef enum logic {
        MODE_RETRIG  = 1'b0,   // a new trigger reloads the interval
        MODE_LOCKOUT = 1'b1    // triggers ignored while the pulse is high
    } retrig_mode_e;

endpackage

// File: rtl/os_sync.sv
// Module: os_sync
// Brings WIDTH asynchronous bits into the clk domain through STAGES flops each.
// Assumes: STAGES >= 2; RST_VAL gives each bit's idle level so that reset
// release does not look like an edge to downstream logic.
module os_sync #(
    parameter int unsigned    WIDTH   = 2,
    parameter int unsigned    STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the flop chain, reset to the idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/os_trig_qual.sv
// Module: os_trig_qual
// Detects a falling edge on the active-low trigger and a rising edge on the
// active-high trigger, each gated by the other trigger's level and by clear.
// Assumes: inputs are already synchronized to clk; clr_n is synchronous.
// The previous-sample registers keep tracking during clear so that an edge
// that happened under clear is not replayed after release.
module os_trig_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_n_s,   // synchronized active-low trigger
    input  logic rise_s,     // synchronized active-high trigger
    input  logic clr_n,
    output logic trig_ok     // one-cycle qualified trigger
);

    logic fall_n_prev;
    logic rise_prev;
    logic fall_hit;
    logic rise_hit;

    // Hold last cycle's synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_n_prev <= 1'b1;
            rise_prev   <= 1'b0;
        end else begin
            fall_n_prev <= fall_n_s;
            rise_prev   <= rise_s;
        end
    end

    // Qualify each edge with the opposite pin's enabling level and with clear.
    always_comb begin
        fall_hit = fall_n_prev & ~fall_n_s & ~rise_s;
        rise_hit = ~rise_prev & rise_s & fall_n_s;
        trig_ok  = clr_n & (fall_hit | rise_hit);
    end

endmodule

// File: rtl/os_timer.sv
// Module: os_timer
// Holds the pulse-active state and the cycles-remaining counter.
// Assumes: trig_ok is a single-cycle qualified trigger. A length of zero is
// treated as one. Clear has priority over trigger, trigger over counting.
module os_timer
    import oneshot_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             trig_ok,
    input  retrig_mode_e     mode,
    input  logic [CNT_W-1:0] len,
    output logic             run_q,
    output logic [CNT_W-1:0] rem_q
);

    logic [CNT_W-1:0] load_val;
    logic             accept;

    // Clamp the programmed length to at least one cycle.
    always_comb begin
        load_val = (len == '0) ? CNT_W'(1) : len;
    end

    // Lockout mode refuses triggers while the pulse is running.
    always_comb begin
        accept = trig_ok & ~((mode == MODE_LOCKOUT) & run_q);
    end

    // Start, reload, count down and stop the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            run_q <= 1'b0;
            rem_q <= '0;
        end else if (accept) begin
            run_q <= 1'b1;
            rem_q <= load_val;
        end else if (run_q) begin
            if (rem_q == CNT_W'(1)) begin
                run_q <= 1'b0;
                rem_q <= '0;
            end else begin
                rem_q <= rem_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/retrig_oneshot.sv
// Module: retrig_oneshot (top)
// Digital retriggerable, resettable one-shot. Two asynchronous trigger pins are
// synchronized and qualified. A counter times the pulse, and clear gates the
// output combinationally so that it drops in the same cycle.
// Assumes: clr_n, no_retrig and pulse_len are synchronous to clk.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fall_n,
    input  logic             trig_rise,
    input  logic             clr_n,
    input  logic             no_retrig,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             pulse_q,
    output logic             pulse_qn
);

    logic [1:0]       trig_s;   // [1] = active-low pin, [0] = active-high pin
    logic             trig_ok;
    logic             run_q;
    logic [CNT_W-1:0] rem_q;
    retrig_mode_e     mode;

    os_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({trig_fall_n, trig_rise}),
        .q     (trig_s)
    );

    os_trig_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_n_s (trig_s[1]),
        .rise_s   (trig_s[0]),
        .clr_n    (clr_n),
        .trig_ok  (trig_ok)
    );

    // Translate the mode pin into the shared mode type.
    always_comb begin
        mode = no_retrig ? MODE_LOCKOUT : MODE_RETRIG;
    end

    os_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .trig_ok (trig_ok),
        .mode    (mode),
        .len     (pulse_len),
        .run_q   (run_q),
        .rem_q   (rem_q)
    );

    // Clear forces the output low without waiting for a clock edge.
    always_comb begin
        pulse_q  = run_q & clr_n;
        pulse_qn = ~pulse_q;
    end

endmodule

// File: rtl/retrig_oneshot_chk.sv
// Module: retrig_oneshot_chk
// Temporal properties for retrig_oneshot, attached by bind below.
// Assumes: it observes the top's ports and its internal trigger/timer nets.
module retrig_oneshot_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             no_retrig,
    input logic [CNT_W-1:0] pulse_len,
    input logic             trig_ok,
    input logic             run_q,
    input logic [CNT_W-1:0] rem_q
);

    logic [CNT_W-1:0] want_len;

    // Expected reload value for a trigger seen this cycle.
    always_comb begin
        want_len = (pulse_len == '0) ? CNT_W'(1) : pulse_len;
    end

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ok && !run_q) |=> (run_q && rem_q == $past(want_len))) else $error("start");          // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ok && !no_retrig) |=> (run_q && rem_q == $past(want_len))) else $error("reload");     // R6
    AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !run_q) else $error("clear");                                                   // R7
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clr_n) && !trig_ok) |=> !run_q) else $error("release");                              // R8
    AST_LOCKOUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && no_retrig && clr_n && rem_q > CNT_W'(1)) |=> rem_q == $past(rem_q) - CNT_W'(1)) else $error("lockout"); // R10
    AST_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && clr_n && !trig_ok && rem_q == CNT_W'(1)) |=> !run_q) else $error("end");          // R5
    AST_NO_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> rem_q != '0) else $error("zero");                                                // R5

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .no_retrig (no_retrig),
    .pulse_len (pulse_len),
    .trig_ok   (trig_ok),
    .run_q     (run_q),
    .rem_q     (rem_q)
);

// File: tb/retrig_oneshot_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue the expected output per cycle and a
// monitor compares at each falling edge.
module retrig_oneshot_bench;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_fall_n = 1'b1;
    logic             trig_rise = 1'b0;
    logic             clr_n = 1'b1;
    logic             no_retrig = 1'b0;
    logic [CNT_W-1:0] pulse_len = 8'd5;
    logic             pulse_q;
    logic             pulse_qn;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    retrig_oneshot #(.CNT_W(CNT_W)) u_retrig_oneshot (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_n (trig_fall_n),
        .trig_rise   (trig_rise),
        .clr_n       (clr_n),
        .no_retrig   (no_retrig),
        .pulse_len   (pulse_len),
        .pulse_q     (pulse_q),
        .pulse_qn    (pulse_qn)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item due this cycle and compare.
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            e = sb.pop_front();
            n_chk++;
            if (e.cyc != cyc || pulse_q !== e.val) begin
                n_fail++;
                $display("FAIL %s cycle %0d: pulse_q=%b expected %b (item cycle %0d)",
                         e.tag, cyc, pulse_q, e.val, e.cyc);
            end
            n_chk++;
            if (pulse_qn !== ~e.val) begin
                n_fail++;
                $display("FAIL R11 cycle %0d: pulse_qn=%b expected %b", cyc, pulse_qn, ~e.val);
            end
        end
    end

    task automatic push(int from, int to, logic v, string tag);
        for (int c = from; c <= to; c++) sb.push_back('{c, v, tag});
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Pulse driven in cycle k: low to k+2, high for len cycles, then low twice.
    task automatic expect_pulse(int k, int len, string tag);
        push(k, k + 2, 1'b0, tag);
        push(k + 3, k + 2 + len, 1'b1, tag);
        push(k + 3 + len, k + 4 + len, 1'b0, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int k;
        int m;
        int p;
        // R1: reset state
        step(3);
        push(cyc, cyc + 4, 1'b0, "R1");
        rst_n = 1'b1;
        step(5);

        // R2: falling trigger, length 5 (R5)
        k = cyc;
        trig_fall_n = 1'b0;
        expect_pulse(k, 5, "R2");
        step(2);
        trig_fall_n = 1'b1;
        step(8);

        // R3: rising trigger, length 3
        pulse_len = 8'd3;
        k = cyc;
        trig_rise = 1'b1;
        expect_pulse(k, 3, "R3");
        step(2);
        trig_rise = 1'b0;
        step(6);

        // R5: zero length acts as one, then length one
        pulse_len = 8'd0;
        k = cyc;
        trig_rise = 1'b1;
        expect_pulse(k, 1, "R5");
        step(1);
        trig_rise = 1'b0;
        step(5);
        pulse_len = 8'd1;
        k = cyc;
        trig_fall_n = 1'b0;
        expect_pulse(k, 1, "R5");
        step(1);
        trig_fall_n = 1'b1;
        step(5);

        // R8: rising edge hidden under clear, then bare release
        pulse_len = 8'd4;
        k = cyc;
        clr_n = 1'b0;
        trig_rise = 1'b1;
        push(k, k + 8, 1'b0, "R8");
        step(4);
        clr_n = 1'b1;
        step(5);
        // R4: falling edge blocked while trig_rise high
        m = cyc;
        trig_fall_n = 1'b0;
        push(m, m + 6, 1'b0, "R4");
        step(4);
        trig_rise = 1'b0;
        step(3);
        // R4: rising edge blocked while trig_fall_n low
        p = cyc;
        trig_rise = 1'b1;
        push(p, p + 9, 1'b0, "R4");
        step(3);
        trig_rise = 1'b0;
        trig_fall_n = 1'b1;
        step(7);

        // R6: retrigger during pulse extends it
        pulse_len = 8'd6;
        k = cyc;
        trig_rise = 1'b1;
        push(k, k + 2, 1'b0, "R6");
        push(k + 3, k + 12, 1'b1, "R6");
        push(k + 13, k + 14, 1'b0, "R6");
        step(1);
        trig_rise = 1'b0;
        step(3);
        trig_rise = 1'b1;
        step(1);
        trig_rise = 1'b0;
        step(10);

        // R10: lockout ignores a second trigger, then accepts a later one
        no_retrig = 1'b1;
        k = cyc;
        trig_rise = 1'b1;
        push(k, k + 2, 1'b0, "R10");
        push(k + 3, k + 8, 1'b1, "R10");
        push(k + 9, k + 10, 1'b0, "R10");
        step(1);
        trig_rise = 1'b0;
        step(3);
        trig_rise = 1'b1;
        step(1);
        trig_rise = 1'b0;
        step(6);
        k = cyc;
        trig_fall_n = 1'b0;
        expect_pulse(k, 6, "R10");
        step(1);
        trig_fall_n = 1'b1;
        step(10);
        no_retrig = 1'b0;

        // R7: clear mid-pulse ends it, trigger under clear ignored
        pulse_len = 8'd10;
        k = cyc;
        trig_rise = 1'b1;
        push(k, k + 2, 1'b0, "R7");
        push(k + 3, k + 4, 1'b1, "R7");
        push(k + 5, k + 15, 1'b0, "R7");
        step(1);
        trig_rise = 1'b0;
        step(4);
        clr_n = 1'b0;
        step(1);
        trig_rise = 1'b1;
        step(1);
        trig_rise = 1'b0;
        step(5);
        clr_n = 1'b1;
        step(4);

        // R9: clear released in the edge-detect cycle, trigger accepted
        pulse_len = 8'd4;
        k = cyc;
        clr_n = 1'b0;
        trig_rise = 1'b1;
        expect_pulse(k, 4, "R9");
        step(1);
        trig_rise = 1'b0;
        step(1);
        clr_n = 1'b1;
        step(7);

        // R8: clear released one cycle after the edge, no pulse
        k = cyc;
        clr_n = 1'b0;
        trig_rise = 1'b1;
        push(k, k + 7, 1'b0, "R8");
        step(1);
        trig_rise = 1'b0;
        step(2);
        clr_n = 1'b1;
        step(5);

        // R12: length change mid-pulse has no effect
        pulse_len = 8'd4;
        k = cyc;
        trig_fall_n = 1'b0;
        expect_pulse(k, 4, "R12");
        step(1);
        trig_fall_n = 1'b1;
        step(3);
        pulse_len = 8'd20;
        step(5);

        step(2);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        summary();
        $finish;
    end

endmodule